// File: doc/BRIEF.md
# Mode-Aware Watchdog Timer

This block is a watchdog built from a free-running base counter and a programmable postscaler, both advanced by a slow tick from an external oscillator. When the postscaled count reaches its terminal value, the block acts according to the processor's current power state. If the core is executing code, it issues a one-cycle watchdog reset pulse. If the core is in sleep or any idle state, it issues a one-cycle wake request instead.

Four independent events restart the whole count, base counter and postscaler together. They are a software watchdog clear, entry into sleep, loss of the selected clock, and a change of the clock-frequency setting. A sticky status field records which action the most recent expiry took. Only the software clear empties it.

Top module: `wdt_mode_guard`

## Requirements
- R1: `pwr_mode` is encoded 0 = run, 1 = idle, 2 = sleep, 3 = doze (a second idle state). An expiry while `pwr_mode` is 1, 2 or 3 produces a pulse on `wake_req` and none on `wdt_rst`.
- R2: An expiry while `pwr_mode` is 0 (run) produces a pulse on `wdt_rst` and none on `wake_req`.
- R3: With postscaler select N (`ps_sel`, 0 to 2^SEL_W-1), expiry happens on the 2^(BASE_W+N)-th tick since the last clear. Cycles with `tick` low do not advance the count. The count then wraps, and the next expiry follows after the same number of ticks.
- R4: A high `sw_clr` restarts the base counter and the postscaler from zero.
- R5: A high `sleep_enter` restarts the base counter and the postscaler from zero.
- R6: A high `clk_lost` restarts the base counter and the postscaler from zero.
- R7: A high `freq_chg` restarts the base counter and the postscaler from zero.
- R8: `wake_req` and `wdt_rst` are each high for exactly one cycle per expiry. They are never high together.
- R9: `to_status` is 0 after reset, 1 after an expiry that woke the core, and 2 after an expiry that reset it. It holds its value until the next expiry. Only `sw_clr` returns it to 0; `sleep_enter`, `clk_lost` and `freq_chg` leave it unchanged.
- R10: When any clear source is high in the same cycle as the expiring tick, no pulse is produced, the status is unchanged, and the count restarts from zero.
- R11: The pulse is registered. It appears on the outputs right after the clock edge that samples the expiring tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Slow time-base tick, one count per high cycle |
| ps_sel | input | SEL_W | Postscaler exponent N (ratio 2^N) |
| sw_clr | input | 1 | Software watchdog clear pulse |
| sleep_enter | input | 1 | Sleep-entry pulse |
| clk_lost | input | 1 | Selected clock lost pulse |
| freq_chg | input | 1 | Clock-frequency setting changed pulse |
| pwr_mode | input | 2 | Current power state (0 run, 1 idle, 2 sleep, 3 doze) |
| wake_req | output | 1 | One-cycle wake request |
| wdt_rst | output | 1 | One-cycle watchdog reset |
| to_status | output | 2 | Sticky record of last expiry action |

## Verification
Every result of this block is due one clock edge after its cause. A pulse and its status update follow the edge that samples the expiring tick. A restart by a clear source takes effect at the edge that samples it. The bench drives inputs on the falling edge and samples the outputs on the next falling edge, so each check reads the cycle in which the result is due. Before the final tick of each expiry window, the bench checks every cycle for the absence of a pulse. After the pulse, it checks one more cycle for its removal.

// File: rtl/wdtg_pkg.sv
package wdtg_pkg;

   typedef enum logic [1:0] {
      PM_RUN   = 2'd0,
      PM_IDLE  = 2'd1,
      PM_SLEEP = 2'd2,
      PM_DOZE  = 2'd3
   } pwr_mode_e;

   typedef enum logic [1:0] {
      TS_NONE  = 2'd0,
      TS_WOKE  = 2'd1,
      TS_RESET = 2'd2
   } to_stat_e;

   localparam int unsigned NUM_CLR_SRC = 4;

endpackage

// File: rtl/wdtg_clear_merge.sv
module wdtg_clear_merge #(
   parameter int unsigned NSRC = 4
) (
   input  logic [NSRC-1:0] src,
   output logic            clr
);

   if (NSRC < 1) begin : g_bad
      $error("wdtg_clear_merge: NSRC must be at least 1");
   end

   logic [NSRC:0] chain;

   assign chain[0] = 1'b0;
   for (genvar i = 0; i < NSRC; i++) begin : g_or
      assign chain[i+1] = chain[i] | src[i];
   end

   assign clr = chain[NSRC];

endmodule

// File: rtl/wdtg_base_cnt.sv
module wdtg_base_cnt #(
   parameter int unsigned W = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic tick,
   output logic carry
);

   if (W < 1) begin : g_bad
      $error("wdtg_base_cnt: W must be at least 1");
   end

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clr)
         cnt_q <= '0;
      else if (tick)
         cnt_q <= cnt_q + 1'b1;
   end

   assign carry = tick & (&cnt_q);

endmodule

// File: rtl/wdtg_post_cnt.sv
module wdtg_post_cnt #(
   parameter int unsigned SEL_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             step,
   input  logic [SEL_W-1:0] sel,
   output logic             term_hit
);

   localparam int unsigned PS_W = (1 << SEL_W) - 1;

   if (SEL_W < 1 || SEL_W > 5) begin : g_bad
      $error("wdtg_post_cnt: SEL_W must lie in 1..5");
   end

   logic            at_term;

   if (PS_W == 0) begin : g_nops
      assign at_term = 1'b1;
   end else begin : g_ps
      logic [PS_W-1:0] ps_q;
      logic [PS_W-1:0] mask;

      for (genvar b = 0; b < PS_W; b++) begin : g_mask
         assign mask[b] = (32'(sel) > 32'(b));
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            ps_q <= '0;
         else if (clr)
            ps_q <= '0;
         else if (step)
            ps_q <= ps_q + 1'b1;
      end

      assign at_term = &(ps_q | ~mask);
   end

   assign term_hit = step & at_term;

endmodule

// File: rtl/wdtg_action.sv
module wdtg_action
   import wdtg_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       expire,
   input  logic       sw_clr,
   input  pwr_mode_e  mode,
   output logic       wake_req,
   output logic       wdt_rst,
   output to_stat_e   status
);

   logic core_running;

   assign core_running = (mode == PM_RUN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wake_req <= 1'b0;
         wdt_rst  <= 1'b0;
      end else begin
         wake_req <= expire & ~core_running;
         wdt_rst  <= expire &  core_running;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         status <= TS_NONE;
      else if (sw_clr)
         status <= TS_NONE;
      else if (expire)
         status <= core_running ? TS_RESET : TS_WOKE;
   end

endmodule

// File: rtl/wdt_mode_guard.sv
module wdt_mode_guard
   import wdtg_pkg::*;
#(
   parameter int unsigned BASE_W = 8,
   parameter int unsigned SEL_W  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [SEL_W-1:0] ps_sel,
   input  logic             sw_clr,
   input  logic             sleep_enter,
   input  logic             clk_lost,
   input  logic             freq_chg,
   input  logic [1:0]       pwr_mode,
   output logic             wake_req,
   output logic             wdt_rst,
   output logic [1:0]       to_status
);

   logic clr_any;
   logic base_carry;
   logic term_hit;
   logic expire;
   to_stat_e status_q;

   wdtg_clear_merge #(.NSRC(NUM_CLR_SRC)) u_clr (
      .src ({freq_chg, clk_lost, sleep_enter, sw_clr}),
      .clr (clr_any)
   );

   wdtg_base_cnt #(.W(BASE_W)) u_base (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr_any),
      .tick  (tick),
      .carry (base_carry)
   );

   wdtg_post_cnt #(.SEL_W(SEL_W)) u_post (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr_any),
      .step     (base_carry),
      .sel      (ps_sel),
      .term_hit (term_hit)
   );

   assign expire = term_hit & ~clr_any;

   wdtg_action u_act (
      .clk      (clk),
      .rst_n    (rst_n),
      .expire   (expire),
      .sw_clr   (sw_clr),
      .mode     (pwr_mode_e'(pwr_mode)),
      .wake_req (wake_req),
      .wdt_rst  (wdt_rst),
      .status   (status_q)
   );

   assign to_status = status_q;

endmodule

// File: rtl/wdtg_checker.sv
module wdtg_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       sw_clr,
   input logic       sleep_enter,
   input logic       clk_lost,
   input logic       freq_chg,
   input logic [1:0] pwr_mode,
   input logic       wake_req,
   input logic       wdt_rst,
   input logic [1:0] to_status
);

   AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(wake_req && wdt_rst)); // R8

   AST_WAKE_ONE_CYC: assert property (@(posedge clk) disable iff (!rst_n)
      wake_req |=> !wake_req); // R8

   AST_RST_ONE_CYC: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_rst |=> !wdt_rst); // R8

   AST_WAKE_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
      wake_req |-> $past(pwr_mode) != 2'd0); // R1

   AST_RST_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_rst |-> $past(pwr_mode) == 2'd0); // R2

   AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      $past(sw_clr || sleep_enter || clk_lost || freq_chg) |-> !(wake_req || wdt_rst)); // R10

   AST_STATUS_SWCLR: assert property (@(posedge clk) disable iff (!rst_n)
      $past(sw_clr) |-> to_status == 2'd0); // R9

   AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (to_status != $past(to_status)) |-> (wake_req || wdt_rst || $past(sw_clr))); // R9

   AST_STATUS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      wake_req |-> to_status == 2'd1); // R9

endmodule

bind wdt_mode_guard wdtg_checker u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .sw_clr      (sw_clr),
   .sleep_enter (sleep_enter),
   .clk_lost    (clk_lost),
   .freq_chg    (freq_chg),
   .pwr_mode    (pwr_mode),
   .wake_req    (wake_req),
   .wdt_rst     (wdt_rst),
   .to_status   (to_status)
);

// File: tb/wdt_mode_guard_tb.sv
module wdt_mode_guard_tb;

   localparam int BASE_W = 5;
   localparam int SEL_W  = 4;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             tick = 1'b0;
   logic [SEL_W-1:0] ps_sel = '0;
   logic             sw_clr = 1'b0;
   logic             sleep_enter = 1'b0;
   logic             clk_lost = 1'b0;
   logic             freq_chg = 1'b0;
   logic [1:0]       pwr_mode = 2'd0;
   logic             wake_req;
   logic             wdt_rst;
   logic [1:0]       to_status;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;

   wdt_mode_guard #(.BASE_W(BASE_W), .SEL_W(SEL_W)) u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick        (tick),
      .ps_sel      (ps_sel),
      .sw_clr      (sw_clr),
      .sleep_enter (sleep_enter),
      .clk_lost    (clk_lost),
      .freq_chg    (freq_chg),
      .pwr_mode    (pwr_mode),
      .wake_req    (wake_req),
      .wdt_rst     (wdt_rst),
      .to_status   (to_status)
   );

   // {ps_sel[3:0], pwr_mode[1:0], expect_wake, expect_rst}
   localparam logic [7:0] VEC [0:5] = '{
      8'b0000_00_0_1,
      8'b0001_01_1_0,
      8'b0010_10_1_0,
      8'b0000_11_1_0,
      8'b0001_00_0_1,
      8'b0011_10_1_0
   };

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // drive one cycle: inputs set after a falling edge, outputs read at the next one
   task automatic cyc(logic t, logic sc, logic se, logic cl, logic fc);
      tick = t; sw_clr = sc; sleep_enter = se; clk_lost = cl; freq_chg = fc;
      @(negedge clk);
      tick = 1'b0; sw_clr = 1'b0; sleep_enter = 1'b0; clk_lost = 1'b0; freq_chg = 1'b0;
   endtask

   // n ticks with no pulse expected after any of them
   task automatic quiet_ticks(int n, string req);
      int bad = 0;
      for (int i = 0; i < n; i++) begin
         cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
         if (wake_req || wdt_rst) bad++;
      end
      chk(req, bad, 0);
   endtask

   // final tick of a window; checks the pulse, then its removal
   task automatic last_tick(logic ew, logic er, string req);
      cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
      chk({req, " wake"}, int'(wake_req), int'(ew));
      chk({req, " rst"},  int'(wdt_rst),  int'(er));
      cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      chk("R8 pulse gone", int'(wake_req || wdt_rst), 0);
   endtask

   task automatic run_all;
      int per;
      @(negedge clk);
      @(negedge clk);
      // reset state (R9, R8)
      chk("R9 status after reset", int'(to_status), 0);
      chk("R8 no pulse after reset", int'(wake_req || wdt_rst), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // table walk (R1, R2, R3, R11)
      for (int v = 0; v < 6; v++) begin
         ps_sel   = VEC[v][7:4];
         pwr_mode = VEC[v][3:2];
         cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
         chk("R9 swclr empties status", int'(to_status), 0);
         per = 1 << (BASE_W + int'(VEC[v][7:4]));
         quiet_ticks(per - 1, "R3 no early expiry");
         last_tick(VEC[v][1], VEC[v][0], VEC[v][1] ? "R1 R11" : "R2 R11");
         chk("R9 status records action", int'(to_status), VEC[v][1] ? 1 : 2);
      end

      // R3: idle cycles between ticks do not count; wrap gives same period
      ps_sel = '0; pwr_mode = 2'd0;
      cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
      for (int i = 0; i < 31; i++) begin
         cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
         cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      end
      chk("R3 gaps no expiry", int'(wake_req || wdt_rst), 0);
      last_tick(1'b0, 1'b1, "R3 gapped ticks");
      quiet_ticks(31, "R3 wrap no early");
      last_tick(1'b0, 1'b1, "R3 wrap period");

      // R5 R6 R7 R4: each clear source restarts the count
      pwr_mode = 2'd1;
      for (int s = 0; s < 4; s++) begin
         cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
         quiet_ticks(20, "R4 prefill");
         case (s)
            0: cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0); // R4
            1: cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b0); // R5
            2: cyc(1'b0, 1'b0, 1'b0, 1'b1, 1'b0); // R6
            default: cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b1); // R7
         endcase
         quiet_ticks(31, s == 0 ? "R4 restart" : s == 1 ? "R5 restart" :
                         s == 2 ? "R6 restart" : "R7 restart");
         last_tick(1'b1, 1'b0, "R1 after restart");
      end

      // R9: non-software clears leave status alone
      chk("R9 status woke", int'(to_status), 1);
      cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
      cyc(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
      cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
      chk("R9 status kept by other clears", int'(to_status), 1);

      // R9: status switches from reset record to wake record
      pwr_mode = 2'd0;
      cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
      quiet_ticks(31, "R3 run window");
      last_tick(1'b0, 1'b1, "R2 run");
      chk("R9 status reset", int'(to_status), 2);
      pwr_mode = 2'd2;
      quiet_ticks(31, "R3 sleep window");
      last_tick(1'b1, 1'b0, "R1 sleep");
      chk("R9 status woke again", int'(to_status), 1);

      // R10: clear on the expiring tick wins
      pwr_mode = 2'd0;
      cyc(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
      quiet_ticks(31, "R10 prefill");
      cyc(1'b1, 1'b0, 1'b0, 0'b0 == 0 ? 1'b1 : 1'b1, 1'b0);
      chk("R10 no pulse on clash", int'(wake_req || wdt_rst), 0);
      chk("R10 status unchanged", int'(to_status), 1);
      quiet_ticks(31, "R10 restart");
      last_tick(1'b0, 1'b1, "R10 full window");
      quiet_ticks(31, "R10 prefill swclr");
      cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
      chk("R10 swclr clash no pulse", int'(wake_req || wdt_rst), 0);
      chk("R9 swclr clash status", int'(to_status), 0);
   endtask

   initial begin
      fork
         run_all();
         begin
            repeat (200000) @(posedge clk);
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=done");
         end
      join_any
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule